// File: doc/BRIEF.md
# Half-Word Masked Control Register Bank

This block is a small bank of control registers for a set of clock generators. Each register stores 16 bits. Every write carries 32 bits: the low half is the new data and the high half says, bit by bit, which stored bits may change. Software can therefore set or clear one field of a register in a single write. It needs no read-modify-write and no lock around shared registers.

The bank has one group of four words per clock generator, with a byte stride of 0x10 between groups. One shared mode register sits at offset 0x40. In that register each generator owns a 2-bit mode field, at shifts 0, 4, 8 and 12 in generator order. In the fourth word of each group, bit 1 is the generator's reset and bit 0 its bypass. To update a field of value v, mask m and shift s, software writes `(v << s) | (m << (s + 16))`. Several fields of one register can change in a single write by OR-ing their value/mask pairs together. Reads are combinational: they return the stored 16 bits in the low half, and the high half always reads zero.

Top module: `hmr_bank`

## Requirements
- R1: On a write to a mapped offset, stored bit i takes write-data bit i when write-data bit i+16 is 1, and keeps its old value when bit i+16 is 0. The new value is readable from the clock edge that takes the write.
- R2: A write whose bits 31:16 are all zero leaves the addressed register unchanged.
- R3: Read data bits 31:16 are always zero.
- R4: While synchronous active-low reset is held at a clock edge, every register clears to zero. This puts every mode field at 0, which is slow mode.
- R5: Mapped word w (0..3) of group g (0..3) sits at byte offset g*0x10 + w*4. A write changes only the register at its own offset.
- R6: The mode register at offset 0x40 holds four 2-bit fields at shifts 0, 4, 8 and 12. A masked write to one field leaves the other fields as they were. Two fields can be updated in one write.
- R7: Writes to any unmapped offset, including unaligned ones and everything above 0x40, change no register. Reads of an unmapped offset return zero.
- R8: With the write strobe low, no register changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Bits 31:16 bit-enable mask, bits 15:0 data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data, stored value in bits 15:0 |

## Verification
The bench builds the block with its default parameters: four groups of four words, stride 0x10, mode register at 0x40 and an 8-bit address. With an 8-bit address the whole space is only 256 offsets. So after every write the bench reads back every offset, mapped or not, against an arithmetic model. A write to each of the 256 offsets, with pseudo-random data and masks, brings every decode corner within reach. The same sweep covers unaligned offsets, the gap above the mode register, and the isolation of each register from its neighbours. Directed writes to the mode fields, zero-mask writes, strobe-low writes and a mid-run reset complete the coverage.

// File: rtl/hmr_pkg.sv
// Package: shared widths for the half-word masked register bank.
// Assumes a 32-bit write word whose upper half is a per-bit write enable.
package hmr_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/hmr_decode.sv
// Module: hmr_decode
// Maps a byte offset to a register index. Group g, word w sits at
// g*GROUP_STRIDE + 4*w. The mode register at MODE_OFFSET takes the last index.
// Assumes GROUP_STRIDE is a power of two and at least 4*WORDS_PER_GROUP.
module hmr_decode #(
    parameter int ADDR_W          = 8,
    parameter int NUM_GROUPS      = 4,
    parameter int WORDS_PER_GROUP = 4,
    parameter int GROUP_STRIDE    = 16,
    parameter int MODE_OFFSET     = 64,
    localparam int NUM_REGS       = NUM_GROUPS * WORDS_PER_GROUP + 1,
    localparam int IDX_W          = $clog2(NUM_REGS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int STRIDE_SH = $clog2(GROUP_STRIDE);

    logic [ADDR_W-1:0] grp;
    logic [ADDR_W-1:0] wrd;

    assign grp = addr >> STRIDE_SH;
    assign wrd = (addr & ADDR_W'(GROUP_STRIDE - 1)) >> 2;

    // Purpose: pick the mode register, a group word, or report no hit.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        if (addr == ADDR_W'(MODE_OFFSET)) begin
            hit = 1'b1;
            idx = IDX_W'(NUM_REGS - 1);
        end else if (addr[1:0] == 2'b00 && grp < ADDR_W'(NUM_GROUPS) &&
                     wrd < ADDR_W'(WORDS_PER_GROUP)) begin
            hit = 1'b1;
            idx = IDX_W'(grp * ADDR_W'(WORDS_PER_GROUP) + wrd);
        end
    end
endmodule

// File: rtl/hmr_cell.sv
// Module: hmr_cell
// One 16-bit register. On a write, each bit loads its data bit only when the
// matching mask bit in the upper half is set. Synchronous active-low reset.
module hmr_cell
    import hmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  word_t wdata,
    output half_t q
);
    half_t mask;
    half_t data;

    assign mask = wdata[WORD_W-1:HALF_W];
    assign data = wdata[HALF_W-1:0];

    // Purpose: clear on reset, otherwise update the enabled bits one by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            for (int i = 0; i < HALF_W; i++) begin
                if (mask[i]) q[i] <= data[i];
            end
        end
    end

    assert_masked_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((q & $past(mask)) == ($past(data) & $past(mask))));
    assert_unmasked_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (((q ^ $past(q)) & ~$past(mask)) == '0));
    assert_zero_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && mask == '0) |=> $stable(q));
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/hmr_bank.sv
// Module: hmr_bank (top)
// Bank of half-word masked control registers: a group of words per clock
// generator and one shared mode register. Writes take effect at the clock
// edge. Reads are combinational, and the upper half always reads zero.
module hmr_bank
    import hmr_pkg::*;
#(
    parameter int ADDR_W          = 8,
    parameter int NUM_GROUPS      = 4,
    parameter int WORDS_PER_GROUP = 4,
    parameter int GROUP_STRIDE    = 16,
    parameter int MODE_OFFSET     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data
);
    localparam int NUM_REGS = NUM_GROUPS * WORDS_PER_GROUP + 1;
    localparam int IDX_W    = $clog2(NUM_REGS);

    logic                wr_hit;
    logic [IDX_W-1:0]    wr_idx;
    logic                rd_hit;
    logic [IDX_W-1:0]    rd_idx;
    logic [NUM_REGS-1:0] we_vec;
    half_t               regs [NUM_REGS];

    hmr_decode #(
        .ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS),
        .WORDS_PER_GROUP(WORDS_PER_GROUP), .GROUP_STRIDE(GROUP_STRIDE),
        .MODE_OFFSET(MODE_OFFSET)
    ) u_wr_dec (.addr(wr_addr), .hit(wr_hit), .idx(wr_idx));

    hmr_decode #(
        .ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS),
        .WORDS_PER_GROUP(WORDS_PER_GROUP), .GROUP_STRIDE(GROUP_STRIDE),
        .MODE_OFFSET(MODE_OFFSET)
    ) u_rd_dec (.addr(rd_addr), .hit(rd_hit), .idx(rd_idx));

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        // Purpose: enable exactly the register the write address selects.
        assign we_vec[r] = wr_en && wr_hit && (wr_idx == IDX_W'(r));

        hmr_cell u_cell (
            .clk(clk), .rst_n(rst_n), .we(we_vec[r]),
            .wdata(wr_data), .q(regs[r])
        );
    end

    // Purpose: return the addressed register in the low half, zero otherwise.
    always_comb begin
        rd_data = '0;
        if (rd_hit) rd_data[HALF_W-1:0] = regs[rd_idx];
    end

    assert_one_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_vec));
    assert_unmapped_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |-> (we_vec == '0));
    assert_strobe_low_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (we_vec == '0));
endmodule

// File: tb/tb_hmr_bank.sv
// Bench: tb_hmr_bank. After each write it reads all 256 offsets and compares
// them with an arithmetic model of the masked-write rule.
module tb_hmr_bank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [31:0] seed = 32'h1234_5678;
    logic [15:0] model [256];

    always #(CLK_PERIOD / 2) clk = ~clk;

    hmr_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // R5/R7: mapped iff word-aligned below 0x40, or exactly 0x40
    function automatic bit is_mapped(input int a);
        return (a == 'h40) || (a < 'h40 && (a % 4) == 0);
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic clear_model();
        for (int a = 0; a < 256; a++) model[a] = '0;
    endtask

    task automatic check_all(input string tag);
        for (int a = 0; a < 256; a++) begin
            rd_addr = 8'(a);
            #1;
            total++;
            if (rd_data !== {16'h0, model[a]}) begin
                bad++;
                $display("FAIL %s addr=%02h actual=%08h expected=%08h",
                         tag, a, rd_data, {16'h0, model[a]});
            end
        end
    endtask

    task automatic do_write(input int a, input logic [31:0] d, input bit en);
        @(negedge clk);
        wr_en = en; wr_addr = 8'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (en && is_mapped(a))
            model[a] = (model[a] & ~d[31:16]) | (d[15:0] & d[31:16]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clear_model();
        // R4: reset clears everything
        wr_en = 1'b1; wr_addr = 8'h00; wr_data = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        wr_en = 1'b0;
        rst_n = 1'b1;
        check_all("R4");

        // R1 R3 R5 R7: one write to every offset with random data and mask
        for (int a = 0; a < 256; a++) begin
            seed = next_rand(seed);
            do_write(a, seed, 1'b1);
            check_all("R1");
        end

        // R1: full-mask writes of fixed patterns to every mapped register
        for (int a = 0; a <= 'h40; a += 4) begin
            do_write(a, {16'hFFFF, 16'(16'hA5C3 ^ a)}, 1'b1);
        end
        check_all("R5");

        // R2: zero-mask writes leave every register unchanged
        for (int a = 0; a <= 'h40; a += 4) begin
            do_write(a, 32'h0000_FFFF, 1'b1);
            do_write(a, 32'h0000_0000, 1'b1);
        end
        check_all("R2");

        // R8: strobe low, full mask, no change
        for (int a = 0; a <= 'h40; a += 4) begin
            do_write(a, 32'hFFFF_5A5A, 1'b0);
        end
        check_all("R8");

        // R7: unmapped offsets, full-mask writes, ignored
        do_write('h02, 32'hFFFF_FFFF, 1'b1);
        do_write('h44, 32'hFFFF_FFFF, 1'b1);
        do_write('hFF, 32'hFFFF_FFFF, 1'b1);
        check_all("R7");

        // R6: each 2-bit mode field in turn, the others are kept
        for (int k = 0; k < 4; k++) begin
            for (int v = 0; v < 4; v++) begin
                do_write('h40, (32'(v) << (4 * k)) | (32'h3 << (4 * k + 16)), 1'b1);
                check_all("R6");
            end
        end
        // R6: two fields in one write (field 0 = 1, field 2 = 2)
        do_write('h40, (32'h1 | (32'h3 << 16)) | ((32'h2 << 8) | (32'h3 << 24)), 1'b1);
        check_all("R6");
        // R6: set reset (bit 1), keep bypass (bit 0), in word 3 of group 2
        do_write('h2C, 32'h0002_0002, 1'b1);
        check_all("R6");

        // R4: reset in mid-run clears the whole bank
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        clear_model();
        check_all("R4");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule